// File: doc/BRIEF.md
# Edge-latched interrupt source register

This block collects eight interrupt conditions from the functions of a sensor core into one 8-bit status byte. Each condition is a level signal. The block registers each condition once and compares it with its current value. A bit of the status byte is latched only when its condition goes from low to high. The bit then stays set until the status register of the function that raised it is read. Firmware reads this byte to learn which functions have something to report. It then reads each of those functions' own status registers, and each of those reads clears the matching bit here.

A combined interrupt line is also produced. It is the OR of the status bits that an external enable mask allows. The enable mask itself lives elsewhere. Routing of the line to pins is outside this block.

Top module: `int_src_latch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the status byte reads 8'h00 and the combined interrupt output is 0.
- R2: A low-to-high change of `cond_i[k]` between two consecutive clock edges sets `stat_o[k]` to 1, visible right after the second of those edges.
- R3: A condition that stays high does not set its bit again after that bit has been cleared.
- R4: A one-cycle pulse on `fn_rd_i[k]` clears `stat_o[k]` at the next edge and leaves every other bit unchanged.
- R5: When a rising edge of `cond_i[k]` and a pulse on `fn_rd_i[k]` fall in the same cycle, `stat_o[k]` ends that cycle at 1.
- R6: The bits are placed as follows: bit 7 is data ready, bit 6 is FIFO, bit 5 is pressure window, bit 4 is temperature window, bit 3 is pressure threshold, bit 2 is temperature threshold, bit 1 is pressure change, and bit 0 is temperature change. `cond_i[k]` and `fn_rd_i[k]` belong to the function at bit k. A bit reads 1 when its function has asserted an interrupt and 0 when it has not.
- R7: `irq_o` is 1 exactly when `stat_o & irq_en_i` is nonzero. It follows a change of `irq_en_i` within the same cycle.
- R8: A set bit is sticky. It stays set when its condition falls or stays high, until its own clearing read arrives. A falling edge never sets a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 8 | Level interrupt conditions, one per function, in R6 order |
| fn_rd_i | input | 8 | One-cycle pulse per function when its own status register is read |
| irq_en_i | input | 8 | Enable mask for the combined interrupt |
| stat_o | output | 8 | Latched status byte |
| irq_o | output | 1 | Combined interrupt, the OR of the enabled set bits |

## Verification
A condition change or a clearing read presented before clock edge N appears on `stat_o` just after edge N. That is one register stage from input to status. `irq_o` adds only combinational logic on top of `stat_o` and `irq_en_i`. The driver changes inputs on the falling edge and pushes the state it expects after the following rising edge. The monitor samples shortly after that rising edge, while every input is still stable, and pops one expected item per driven cycle. Because of this, each comparison lands exactly on the cycle where the result becomes due.

// File: rtl/int_src_latch.sv
module int_src_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cond_i,
  input  logic [7:0] fn_rd_i,
  input  logic [7:0] irq_en_i,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  // bit 7 drdy, 6 fifo, 5 p-window, 4 t-window, 3 p-thresh, 2 t-thresh, 1 p-change, 0 t-change
  logic [7:0] cond_q;
  logic [7:0] rise;
  logic [7:0] flags;

  assign rise = cond_i & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      flags  <= '0;
    end else begin
      cond_q <= cond_i;
      flags  <= (flags & ~fn_rd_i) | rise;
    end
  end

  assign stat_o = flags;
  assign irq_o  = |(flags & irq_en_i);
endmodule

module int_src_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cond_i,
  input logic [7:0] fn_rd_i,
  input logic [7:0] irq_en_i,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  logic [7:0] prev_c;
  logic [7:0] edge_c;
  logic [7:0] clr_c;
  logic [7:0] keep_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_c <= '0;
    else        prev_c <= cond_i;
  end

  assign edge_c = cond_i & ~prev_c;
  assign clr_c  = fn_rd_i & ~edge_c;
  assign keep_c = stat_o & ~fn_rd_i;

  assert_reset_clear_R1: assert property (@(posedge clk) $rose(rst_n) |-> (stat_o == 8'h00 && !irq_o));

  assert_set_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_c != 8'h00) |=> ((stat_o & $past(edge_c)) == $past(edge_c)));

  assert_clear_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c != 8'h00) |=> ((stat_o & $past(clr_c)) == 8'h00));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_c != 8'h00) |=> ((stat_o & $past(keep_c)) == $past(keep_c)));

  assert_no_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_o & ~$past(stat_o) & ~$past(edge_c)) == 8'h00));

  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((stat_o & irq_en_i) != 8'h00));
endmodule

bind int_src_latch int_src_latch_chk u_chk (.*);

// File: tb/tb_int_src_latch.sv
module tb_int_src_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cond_i = '0;
  logic [7:0] fn_rd_i = '0;
  logic [7:0] irq_en_i = 8'hFF;
  logic [7:0] stat_o;
  logic       irq_o;

  int_src_latch dut (.*);

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] stat;
    logic       irq;
    string      req;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_prev = '0;
  logic [7:0] m_flag = '0;
  bit done = 0;

  task automatic check(input logic [7:0] s, input logic i, input logic [7:0] es,
                       input logic ei, input string req);
    n_run++;
    if (s !== es || i !== ei) begin
      n_fail++;
      $display("FAIL %s stat=%h irq=%b expected stat=%h irq=%b", req, s, i, es, ei);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [7:0] rd,
                       input logic [7:0] en, input string req);
    exp_t e;
    @(negedge clk);
    cond_i = c; fn_rd_i = rd; irq_en_i = en;
    m_flag = (m_flag & ~rd) | (c & ~m_prev);
    m_prev = c;
    e.stat = m_flag; e.irq = |(m_flag & en); e.req = req;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(stat_o, irq_o, e.stat, e.irq, e.req);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog stat=%h irq=%b expected completion", stat_o, irq_o);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cond_i = 8'hFF;
    #35;
    check(stat_o, irq_o, 8'h00, 1'b0, "R1 in reset");
    cond_i = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(stat_o, irq_o, 8'h00, 1'b0, "R1 after release");

    drive(8'h01, 8'h00, 8'hFF, "R2 rise bit0");
    drive(8'h01, 8'h00, 8'hFF, "R8 hold high stays set");
    drive(8'h01, 8'h01, 8'hFF, "R4 clear bit0");
    drive(8'h01, 8'h00, 8'hFF, "R3 level high no reset");
    drive(8'h01, 8'h00, 8'hFF, "R3 level high no reset again");
    drive(8'h00, 8'h00, 8'hFF, "R8 fall does not set");
    drive(8'h80, 8'h00, 8'hFF, "R6 data ready at bit7");
    drive(8'h00, 8'h00, 8'hFF, "R8 fall keeps bit7");
    drive(8'h00, 8'h01, 8'hFF, "R4 other clear leaves bit7");
    drive(8'h01, 8'h01, 8'hFF, "R5 rise and clear same cycle");
    drive(8'h01, 8'h00, 8'h02, "R7 masked irq low");
    drive(8'h01, 8'h00, 8'h01, "R7 enabled irq high");
    drive(8'h00, 8'h00, 8'h00, "R7 mask all");
    drive(8'h00, 8'h81, 8'hFF, "R4 clear both");
    for (int k = 0; k < 8; k++) begin
      drive(8'h01 << k, 8'h00, 8'hFF, "R6 walking rise");
      drive(8'h00, 8'h01 << k, 8'hFF, "R4 walking clear");
    end
    drive(8'hA5, 8'h00, 8'hFF, "R2 multi rise");
    drive(8'hFF, 8'h24, 8'h5A, "R5 mixed rise and clear");
    drive(8'h00, 8'h0F, 8'hF0, "R4 low nibble clear");
    drive(8'h00, 8'hF0, 8'hFF, "R4 high nibble clear");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule